// File: doc/BRIEF.md
# Framed Serial DAC Word Loader

This block is the digital front end of a serial-input 12-bit voltage DAC. It watches three serial pins (an active-low frame marker, a serial clock and a data line) plus an active-low load strobe. It collects exactly sixteen bits per frame on falling serial-clock edges and passes the trailing twelve to a holding latch. The latch's parallel value is what the analog converter turns into a voltage.

All pins are brought into one system clock domain through two-flop synchronisers, and their edges are found there. The system clock must run at least four times faster than the serial clock. When the frame marker falls, the level of the load strobe is sampled to pick the update mode. A low level selects automatic update at the end of the word. A high level holds the word until a later falling edge of the strobe. A frame that closes early is thrown away and flagged.

Top module: `sdac_loader`

## Requirements
- R1: After reset the latch output is 0x000 (mid-scale in two's complement), and the update and abort outputs are low.
- R2: With the strobe low when the frame marker falls (auto mode), the latch takes the received word on the 16th falling serial-clock edge, and the update output pulses high for exactly one system clock.
- R3: Of the 16 bits in a frame, the first 4 are discarded. The remaining 12 are taken most significant bit first, so the last bit received is latch bit 0. The code is passed through unchanged as two's complement (0x7FF most positive, 0x800 most negative).
- R4: Falling serial-clock edges after the 16th in a frame are ignored. The held word stays as received.
- R5: With the strobe high when the frame marker falls (strobe mode), the 16th edge leaves the latch unchanged. A later falling strobe edge loads the word and pulses the update output.
- R6: In strobe mode, a falling strobe edge that arrives before all 16 bits are in has no effect. It does not load the latch at that moment, and it does not make the word load by itself later.
- R7: If the frame marker rises before 16 bits have been received, the abort output pulses for one cycle. The latch is left unchanged, and a later strobe edge does not load the partial word.
- R8: A falling frame marker restarts the bit count, so a full frame that follows an aborted one delivers its own word correctly.
- R9: Serial-clock edges while the frame marker is high do not alter the held word.
- R10: In strobe mode a word loads at most once. A second falling strobe edge without a new frame gives no update pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_n_i | input | 1 | Frame marker, low while a word is sent |
| sck_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data |
| ld_n_i | input | 1 | Load strobe; level selects the mode, falling edge loads in strobe mode |
| dac_word_o | output | 12 | Latch contents, two's complement |
| upd_o | output | 1 | One-cycle pulse when the latch is written |
| abort_o | output | 1 | One-cycle pulse when a frame closes short |

## Verification
Whole frames are sent in both modes, with codes picked so that their extreme and alternating patterns show up any bit-order mistake, any leaking header nibble or a lost sign bit. Strobe-mode frames are checked twice: once before the strobe, to show the 16th edge alone does nothing, and once after it. Frames with surplus clock edges, idle clocking between frames, early and repeated strobes, and short frames followed by full ones show whether the counter gate, the arming of the load and the restart at frame start behave as required.

// File: rtl/sdac_pkg.sv
// Package: shared constants and the update-mode type for the serial DAC loader.
// Assumes: nothing; pure type and default definitions.
package sdac_pkg;

    localparam int FRAME_BITS_DEF = 16;
    localparam int WORD_BITS_DEF  = 12;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef enum logic {
        MODE_AUTO   = 1'b0,
        MODE_STROBE = 1'b1
    } upd_mode_e;

endpackage

// File: rtl/sdac_edge_sync.sv
// Module: sdac_edge_sync
// Brings N asynchronous pins into the clk domain through a flop chain of
// DEPTH stages. Gives the synchronised level plus one-cycle falling- and
// rising-edge strobes for each pin.
// Assumes: each pin holds a level for at least two clk periods; RST_VAL is
// the idle level of each pin, so no false edge is seen after reset.
module sdac_edge_sync #(
    parameter int          N       = 4,
    parameter int          DEPTH   = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);

    localparam int LAST = DEPTH - 1;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [DEPTH-1:0] chain;
        logic             prev;

        // Shift the pin through the synchroniser chain and keep one older copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {DEPTH{RST_VAL[i]}};
                prev  <= RST_VAL[i];
            end else begin
                chain <= {chain[DEPTH-2:0], pin_i[i]};
                prev  <= chain[LAST];
            end
        end

        // Derive level and edge strobes from the last stage and its delayed copy.
        always_comb begin
            lvl_o[i]  = chain[LAST];
            fall_o[i] = prev & ~chain[LAST];
            rise_o[i] = ~prev & chain[LAST];
        end
    end

endmodule

// File: rtl/sdac_frame_rx.sv
// Module: sdac_frame_rx
// Frame engine. Opens on a falling frame marker, samples the strobe level to
// choose the mode, and shifts in at most FRAME_BITS bits on serial-clock falls.
// Makes a load request either on the last bit (auto) or on a later strobe
// fall (strobe mode). A frame that closes short raises a one-cycle abort.
// Assumes: all inputs are already synchronous to clk and edges are
// single-cycle strobes.
module sdac_frame_rx
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF,
    parameter int WORD_BITS  = WORD_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_lvl_i,
    input  logic                 frm_fall_i,
    input  logic                 frm_rise_i,
    input  logic                 sck_fall_i,
    input  logic                 sdi_lvl_i,
    input  logic                 ld_lvl_i,
    input  logic                 ld_fall_i,
    output logic                 load_req_o,
    output logic [WORD_BITS-1:0] load_word_o,
    output logic                 abort_o
);

    localparam int CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] FULL     = CW'(FRAME_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

    logic                  active;
    logic [CW-1:0]         cnt;
    logic [FRAME_BITS-1:0] shreg;
    upd_mode_e             mode;
    logic                  armed;
    logic                  abort_q;

    logic shift_en, auto_load, strobe_load;

    // Decode this cycle's shift, auto load and strobe load from the frame state.
    always_comb begin
        shift_en    = active && !frm_lvl_i && sck_fall_i && (cnt != FULL);
        auto_load   = shift_en && (cnt == LAST_BIT) && (mode == MODE_AUTO);
        strobe_load = armed && ld_fall_i && !frm_fall_i;
    end

    // Frame state: open/close, bit count, shift register, mode and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
            mode    <= MODE_AUTO;
            armed   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            if (frm_fall_i) begin
                active <= 1'b1;
                cnt    <= '0;
                shreg  <= '0;
                mode   <= ld_lvl_i ? MODE_STROBE : MODE_AUTO;
                armed  <= 1'b0;
            end else begin
                if (frm_rise_i && active) begin
                    active <= 1'b0;
                    if (cnt != FULL)
                        abort_q <= 1'b1;
                end
                if (shift_en) begin
                    shreg <= {shreg[FRAME_BITS-2:0], sdi_lvl_i};
                    cnt   <= cnt + 1'b1;
                    if ((cnt == LAST_BIT) && (mode == MODE_STROBE))
                        armed <= 1'b1;
                end
                if (strobe_load)
                    armed <= 1'b0;
            end
        end
    end

    // Present the load request and the word that goes with it.
    always_comb begin
        load_req_o  = auto_load || strobe_load;
        load_word_o = auto_load ? {shreg[WORD_BITS-2:0], sdi_lvl_i}
                                : shreg[WORD_BITS-1:0];
        abort_o     = abort_q;
    end

    a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |=> !abort_q);

    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL && !frm_fall_i) |=> $stable(shreg));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !frm_fall_i) |=> ($stable(shreg) && $stable(cnt)));

    a_r5_no_auto_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STROBE && !armed && !frm_fall_i) |-> !load_req_o);

endmodule

// File: rtl/sdac_out_latch.sv
// Module: sdac_out_latch
// Holding latch in front of the converter. Takes the offered word when a
// load is requested and flags the write with a one-cycle update pulse.
// Assumes: load requests are single-cycle; reset value is mid-scale zero.
module sdac_out_latch #(
    parameter int WORD_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 upd_o
);

    // Capture the word on a load and register the update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= load_i;
            if (load_i)
                word_o <= word_i;
        end
    end

    a_r2_update_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

endmodule

// File: rtl/sdac_loader.sv
// Module: sdac_loader (top)
// Serial DAC load interface. Synchronises the four pins, runs the frame
// engine and drives the holding latch whose value feeds the converter.
// Assumes: clk runs at least 4x the serial clock; pins idle high.
module sdac_loader
    import sdac_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF,
    parameter int WORD_BITS  = WORD_BITS_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frm_n_i,
    input  logic                 sck_i,
    input  logic                 sdi_i,
    input  logic                 ld_n_i,
    output logic [WORD_BITS-1:0] dac_word_o,
    output logic                 upd_o,
    output logic                 abort_o
);

    localparam int NPIN = 4;
    localparam int P_FRM = 0;
    localparam int P_SCK = 1;
    localparam int P_SDI = 2;
    localparam int P_LD  = 3;

    logic [NPIN-1:0]      pins, lvl, fall, rise;
    logic                 load_req;
    logic [WORD_BITS-1:0] load_word;

    // Gather the pins into one vector for the synchroniser bank.
    always_comb begin
        pins        = '0;
        pins[P_FRM] = frm_n_i;
        pins[P_SCK] = sck_i;
        pins[P_SDI] = sdi_i;
        pins[P_LD]  = ld_n_i;
    end

    sdac_edge_sync #(
        .N       (NPIN),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL ({NPIN{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .fall_o (fall),
        .rise_o (rise)
    );

    sdac_frame_rx #(
        .FRAME_BITS (FRAME_BITS),
        .WORD_BITS  (WORD_BITS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_lvl_i   (lvl[P_FRM]),
        .frm_fall_i  (fall[P_FRM]),
        .frm_rise_i  (rise[P_FRM]),
        .sck_fall_i  (fall[P_SCK]),
        .sdi_lvl_i   (lvl[P_SDI]),
        .ld_lvl_i    (lvl[P_LD]),
        .ld_fall_i   (fall[P_LD]),
        .load_req_o  (load_req),
        .load_word_o (load_word),
        .abort_o     (abort_o)
    );

    sdac_out_latch #(
        .WORD_BITS (WORD_BITS)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_req),
        .word_i (load_word),
        .word_o (dac_word_o),
        .upd_o  (upd_o)
    );

    a_r7_abort_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !upd_o);

endmodule

// File: tb/sim_sdac_loader.sv
// Bench for sdac_loader: a vector table of whole frames, then directed cases.
module sim_sdac_loader;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int NVEC       = 7;
    // entry: {strobe_mode, 16-bit frame, expected 12-bit word}
    localparam logic [28:0] VECS [NVEC] = '{
        {1'b0, 16'hA7FF, 12'h7FF},
        {1'b0, 16'h5800, 12'h800},
        {1'b0, 16'hF001, 12'h001},
        {1'b0, 16'h0FFF, 12'hFFF},
        {1'b1, 16'h3123, 12'h123},
        {1'b1, 16'hC000, 12'h000},
        {1'b0, 16'h9ABC, 12'hABC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_n = 1'b1, sck = 1'b1, sdi = 1'b0, ld_n = 1'b1;
    logic [11:0] word;
    logic        upd, abrt;

    int checks = 0, errors = 0, upd_cnt = 0, abort_cnt = 0, cyc = 0;
    logic [11:0] prev_word;

    sdac_loader u0 (
        .clk (clk), .rst_n (rst_n), .frm_n_i (frm_n), .sck_i (sck),
        .sdi_i (sdi), .ld_n_i (ld_n), .dac_word_o (word), .upd_o (upd),
        .abort_o (abrt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count output pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && upd)  upd_cnt++;
        if (rst_n && abrt) abort_cnt++;
    end

    // Watchdog: a hung run is a failed check and still gives the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            sck = 1'b1;
            wclk(HALF_SCK);
            sck = 1'b0;
            wclk(HALF_SCK);
        end
        sck = 1'b1;
        wclk(HALF_SCK);
    endtask

    // Full frame: strobe level set first, marker low, bits, marker high.
    task automatic frame(input logic strobe_mode, input logic [31:0] bits, input int n);
        ld_n = strobe_mode;
        wclk(4);
        frm_n = 1'b0;
        wclk(4);
        send_bits(bits, n);
        frm_n = 1'b1;
        wclk(6);
    endtask

    task automatic strobe_pulse();
        ld_n = 1'b0;
        wclk(6);
        ld_n = 1'b1;
        wclk(6);
    endtask

    initial begin
        int u0c, a0c;
        wclk(5);
        // R1: reset state
        chk("R1 word", word, 12'h000);
        chk("R1 upd", upd, 0);
        chk("R1 abort", abrt, 0);
        rst_n = 1'b1;
        wclk(4);
        prev_word = 12'h000;

        // Vector table: R2, R3, R5
        for (int v = 0; v < NVEC; v++) begin
            u0c = upd_cnt;
            a0c = abort_cnt;
            frame(VECS[v][28], {16'h0, VECS[v][27:12]}, 16);
            if (VECS[v][28]) begin
                chk("R5 held before strobe", word, prev_word);
                chk("R5 no update before strobe", upd_cnt - u0c, 0);
                strobe_pulse();
                chk("R5 strobe load", word, VECS[v][11:0]);
                chk("R5 one update", upd_cnt - u0c, 1);
            end else begin
                chk("R2/R3 auto word", word, VECS[v][11:0]);
                chk("R2 one update", upd_cnt - u0c, 1);
            end
            chk("R7 no abort on full frame", abort_cnt - a0c, 0);
            prev_word = word;
        end

        // R4: 20 edges in strobe mode; only the first 16 count
        u0c = upd_cnt;
        frame(1'b1, 32'h000A_5C3F, 20);
        strobe_pulse();
        chk("R4 extra edges ignored", word, 12'h5C3);
        chk("R4 one update", upd_cnt - u0c, 1);

        // R10: second strobe without new frame
        u0c = upd_cnt;
        strobe_pulse();
        chk("R10 no second update", upd_cnt - u0c, 0);
        chk("R10 word kept", word, 12'h5C3);

        // R9: idle clocking with marker high after a strobe-mode frame
        frame(1'b1, {16'h0, 16'h0246}, 16);
        sdi = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sck = 1'b0; wclk(HALF_SCK);
            sck = 1'b1; wclk(HALF_SCK);
        end
        strobe_pulse();
        chk("R9 idle clocks ignored", word, 12'h246);

        // R6: strobe mid-frame in strobe mode
        u0c = upd_cnt;
        ld_n = 1'b1;
        wclk(4);
        frm_n = 1'b0;
        wclk(4);
        send_bits({24'h0, 8'h07}, 8);
        strobe_pulse();
        chk("R6 early strobe no update", upd_cnt - u0c, 0);
        send_bits({24'h0, 8'h77}, 8);
        frm_n = 1'b1;
        wclk(6);
        chk("R6 no late self-load", upd_cnt - u0c, 0);
        chk("R6 word unchanged", word, 12'h246);
        strobe_pulse();
        chk("R6 load after completion", word, 12'h777);

        // R7: short frame in auto mode, then a strobe in strobe mode short frame
        u0c = upd_cnt;
        a0c = abort_cnt;
        frame(1'b0, 32'h0000_03FF, 10);
        chk("R7 abort pulse", abort_cnt - a0c, 1);
        chk("R7 word unchanged", word, 12'h777);
        frame(1'b1, 32'h0000_0155, 9);
        strobe_pulse();
        chk("R7 partial not loaded", upd_cnt - u0c, 0);
        chk("R7 second abort", abort_cnt - a0c, 2);

        // R8: full frame after an abort
        frame(1'b0, {16'h0, 16'hE8A1}, 16);
        chk("R8 restart gives word", word, 12'h8A1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule